// File: doc/BRIEF.md
# Dual-Stage Programmable I/O Slice

This block models a group of programmable pad cells at the edge of a logic array. Each pad's input is taken in two stages. A fast-capture latch runs on a dedicated edge clock and closes on that clock's rising edge. Behind it sits a second stage on the system clock, which is a flip-flop or a level latch depending on a parameter. The core receives two input values per pad. In plain mode these are the registered value and the live fast-latch value. In split mode an address strobe chooses whether a captured word goes into the address holder or the data holder, so a shared address/data bus is separated with no logic in the array.

On the output side, two core signals are combined by a selectable function: select, AND, OR or XOR. The result can be registered on the system clock and can be inverted before it reaches the pad. The pad driver enable comes from a core three-state signal, which can be taken direct or through a register. The enable polarity is set by a mode field. An open-drain option lets a pad pull low only and release it otherwise. Every option is a static configuration input that is set before reset is released.

Top module: `pio_slice`

## Requirements
- R1: The fast latch is transparent while `fast_clk` is low and holds from its rising edge. In plain mode (`cfg_demux`=0), `core_in_a` takes the held value at the next rising `sys_clk` edge. A pad change after the `fast_clk` rise and before that `sys_clk` edge does not reach `core_in_a`.
- R2: In plain mode `core_in_b` shows the fast-latch output directly, so it follows the pad while `fast_clk` is low.
- R3: In split mode (`cfg_demux`=1), a `sys_clk` edge with `addr_strobe`=1 loads `core_in_a` (address) and leaves `core_in_b` unchanged. An edge with `addr_strobe`=0 loads `core_in_b` (data) and leaves `core_in_a` unchanged.
- R4: `cfg_out_fn` selects the output function bitwise. 0 gives `out_sel` ? `core_out_b` : `core_out_a`. 1 gives AND, 2 gives OR and 3 gives XOR.
- R5: With `cfg_out_reg`=1 the function result reaches the pad one `sys_clk` edge later. With 0 it reaches the pad in the same cycle.
- R6: `cfg_out_inv`=1 inverts the pad output value.
- R7: `cfg_oe_mode` sets the driver enable. 0 means always on, 1 means on when the three-state signal is 1, 2 means on when it is 0, and 3 means always off.
- R8: With `cfg_oe_reg`=1 the three-state signal `core_ts` is used one `sys_clk` edge after it is sampled. With 0 it is used at once.
- R9: With `cfg_od`=1 a pad bit whose output value is 1 is released whatever the enable, and a pad bit whose value is 0 is driven low when enabled. A released pad can be driven from outside and read back on `core_in_b`.
- R10: While `rst_n` is low, the fast latch, both input holders, the output register and the enable register are 0.
- R11: `drive_en` shows, per bit, whether the slice drives its pad. A driven pad carries the output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Dedicated fast edge clock for input capture |
| sys_clk | input | 1 | Internal system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_demux | input | 1 | Static: split address/data input mode |
| cfg_out_fn | input | 2 | Static: output combine function |
| cfg_out_reg | input | 1 | Static: register the output value |
| cfg_out_inv | input | 1 | Static: invert the output value |
| cfg_oe_mode | input | 2 | Static: driver enable mode |
| cfg_oe_reg | input | 1 | Static: register the three-state signal |
| cfg_od | input | 1 | Static: open-drain output |
| addr_strobe | input | 1 | Split mode: 1 loads address, 0 loads data |
| core_out_a | input | WIDTH | First core output signal |
| core_out_b | input | WIDTH | Second core output signal |
| out_sel | input | 1 | Select for output function 0 |
| core_ts | input | 1 | Core three-state control |
| core_in_a | output | WIDTH | First input value to the core (address in split mode) |
| core_in_b | output | WIDTH | Second input value to the core (data in split mode) |
| drive_en | output | WIDTH | Per-pad driver enabled |
| pad | inout | WIDTH | Pad nets |

## Verification
The bench builds the slice with four pads and a flip-flop second stage. Four pads are enough to show that the bitwise functions and the open-drain release work on each bit independently: mixed patterns drive some bits and release others in the same cycle. The level-latch second stage is chosen by a parameter and is not exercised. The two clocks are offset so that a pad change can land between the fast-clock rise and the system-clock rise, which exposes the capture point directly.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [1:0] {
      FN_SEL = 2'd0,
      FN_AND = 2'd1,
      FN_OR  = 2'd2,
      FN_XOR = 2'd3
   } out_fn_e;

   typedef enum logic [1:0] {
      OE_ON   = 2'd0,
      OE_HIGH = 2'd1,
      OE_LOW  = 2'd2,
      OE_OFF  = 2'd3
   } oe_mode_e;
endpackage

// File: rtl/pio_in_path.sv
module pio_in_path #(
   parameter int WIDTH       = 4,
   parameter bit IN_STAGE_FF = 1'b1
) (
   input  logic             fast_clk,
   input  logic             sys_clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pad_i,
   input  logic             demux,
   input  logic             strobe,
   output logic [WIDTH-1:0] fast_q,
   output logic [WIDTH-1:0] in_a,
   output logic [WIDTH-1:0] in_b
);
   logic             load_a;
   logic             load_b;
   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] b_q;

   // Fast capture: open while fast_clk is low, closes on its rise.
   always_latch begin
      if (!rst_n)
         fast_q <= '0;
      else if (!fast_clk)
         fast_q <= pad_i;
   end

   assign load_a = demux ? strobe : 1'b1;
   assign load_b = demux & ~strobe;

   generate
      if (IN_STAGE_FF) begin : g_stage_ff
         always_ff @(posedge sys_clk or negedge rst_n) begin
            if (!rst_n) begin
               a_q <= '0;
               b_q <= '0;
            end else begin
               if (load_a) a_q <= fast_q;
               if (load_b) b_q <= fast_q;
            end
         end
      end else begin : g_stage_latch
         always_latch begin
            if (!rst_n)
               a_q <= '0;
            else if (sys_clk && load_a)
               a_q <= fast_q;
         end
         always_latch begin
            if (!rst_n)
               b_q <= '0;
            else if (sys_clk && load_b)
               b_q <= fast_q;
         end
      end
   endgenerate

   assign in_a = a_q;
   assign in_b = demux ? b_q : fast_q;
endmodule

// File: rtl/pio_out_path.sv
module pio_out_path
   import pio_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             sys_clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] src_a,
   input  logic [WIDTH-1:0] src_b,
   input  logic             sel,
   input  out_fn_e          fn,
   input  logic             val_reg,
   input  logic             val_inv,
   input  logic             ts,
   input  logic             ts_reg,
   input  oe_mode_e         oe_mode,
   output logic [WIDTH-1:0] val,
   output logic             en
);
   logic [WIDTH-1:0] comb_v;
   logic [WIDTH-1:0] val_q;
   logic             ts_q;
   logic             ts_use;

   always_comb begin
      unique case (fn)
         FN_SEL:  comb_v = sel ? src_b : src_a;
         FN_AND:  comb_v = src_a & src_b;
         FN_OR:   comb_v = src_a | src_b;
         default: comb_v = src_a ^ src_b;
      endcase
   end

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= '0;
         ts_q  <= 1'b0;
      end else begin
         val_q <= comb_v;
         ts_q  <= ts;
      end
   end

   assign val    = (val_reg ? val_q : comb_v) ^ {WIDTH{val_inv}};
   assign ts_use = ts_reg ? ts_q : ts;

   always_comb begin
      unique case (oe_mode)
         OE_ON:   en = 1'b1;
         OE_HIGH: en = ts_use;
         OE_LOW:  en = ~ts_use;
         default: en = 1'b0;
      endcase
   end
endmodule

// File: rtl/pio_slice.sv
module pio_slice
   import pio_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter bit IN_STAGE_FF = 1'b1
) (
   input  logic             fast_clk,
   input  logic             sys_clk,
   input  logic             rst_n,
   input  logic             cfg_demux,
   input  logic [1:0]       cfg_out_fn,
   input  logic             cfg_out_reg,
   input  logic             cfg_out_inv,
   input  logic [1:0]       cfg_oe_mode,
   input  logic             cfg_oe_reg,
   input  logic             cfg_od,
   input  logic             addr_strobe,
   input  logic [WIDTH-1:0] core_out_a,
   input  logic [WIDTH-1:0] core_out_b,
   input  logic             out_sel,
   input  logic             core_ts,
   output logic [WIDTH-1:0] core_in_a,
   output logic [WIDTH-1:0] core_in_b,
   output logic [WIDTH-1:0] drive_en,
   inout  wire  [WIDTH-1:0] pad
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("pio_slice: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] fast_q;
   logic [WIDTH-1:0] out_val;
   logic             out_en;

   pio_in_path #(.WIDTH(WIDTH), .IN_STAGE_FF(IN_STAGE_FF)) i_in (
      .fast_clk (fast_clk),
      .sys_clk  (sys_clk),
      .rst_n    (rst_n),
      .pad_i    (pad),
      .demux    (cfg_demux),
      .strobe   (addr_strobe),
      .fast_q   (fast_q),
      .in_a     (core_in_a),
      .in_b     (core_in_b)
   );

   pio_out_path #(.WIDTH(WIDTH)) i_out (
      .sys_clk (sys_clk),
      .rst_n   (rst_n),
      .src_a   (core_out_a),
      .src_b   (core_out_b),
      .sel     (out_sel),
      .fn      (out_fn_e'(cfg_out_fn)),
      .val_reg (cfg_out_reg),
      .val_inv (cfg_out_inv),
      .ts      (core_ts),
      .ts_reg  (cfg_oe_reg),
      .oe_mode (oe_mode_e'(cfg_oe_mode)),
      .val     (out_val),
      .en      (out_en)
   );

   // Open drain: a 1 never drives, only a 0 pulls the pad.
   assign drive_en = {WIDTH{out_en}} & ~({WIDTH{cfg_od}} & out_val);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pad
         assign pad[i] = drive_en[i] ? out_val[i] : 1'bz;
      end
   endgenerate
endmodule

// File: rtl/pio_slice_chk.sv
module pio_slice_chk #(
   parameter int WIDTH = 4
) (
   input logic             sys_clk,
   input logic             rst_n,
   input logic             cfg_demux,
   input logic             cfg_od,
   input logic [1:0]       cfg_oe_mode,
   input logic             addr_strobe,
   input logic [WIDTH-1:0] pad,
   input logic [WIDTH-1:0] drive_en,
   input logic [WIDTH-1:0] core_in_a,
   input logic [WIDTH-1:0] core_in_b,
   input logic [WIDTH-1:0] fast_q
);
   p_capture_r1: assert property (@(posedge sys_clk) disable iff (!rst_n)
      !cfg_demux |=> core_in_a == $past(fast_q));

   p_addr_hold_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (cfg_demux && !addr_strobe) |=> $stable(core_in_a));

   p_data_hold_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (cfg_demux && addr_strobe) |=> $stable(core_in_b));

   p_always_on_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (cfg_oe_mode == 2'd0 && !cfg_od) |-> drive_en == {WIDTH{1'b1}});

   p_always_off_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (cfg_oe_mode == 2'd3) |-> drive_en == '0);

   p_od_low_only_r9: assert property (@(posedge sys_clk) disable iff (!rst_n)
      cfg_od |-> (drive_en & pad) == '0);
endmodule

bind pio_slice pio_slice_chk #(.WIDTH(WIDTH)) i_chk (
   .sys_clk     (sys_clk),
   .rst_n       (rst_n),
   .cfg_demux   (cfg_demux),
   .cfg_od      (cfg_od),
   .cfg_oe_mode (cfg_oe_mode),
   .addr_strobe (addr_strobe),
   .pad         (pad),
   .drive_en    (drive_en),
   .core_in_a   (core_in_a),
   .core_in_b   (core_in_b),
   .fast_q      (fast_q)
);

// File: tb/test_pio_slice.sv
module test_pio_slice;
   localparam int CLK_PERIOD = 10;
   localparam int W = 4;

   logic fast_clk = 1'b0;
   logic sys_clk  = 1'b0;
   logic rst_n    = 1'b0;
   logic cfg_demux = 1'b0, cfg_out_reg = 1'b0, cfg_out_inv = 1'b0;
   logic cfg_oe_reg = 1'b0, cfg_od = 1'b0;
   logic [1:0] cfg_out_fn = 2'd0, cfg_oe_mode = 2'd3;
   logic addr_strobe = 1'b0, out_sel = 1'b0, core_ts = 1'b0;
   logic [W-1:0] core_out_a = '0, core_out_b = '0;
   logic [W-1:0] core_in_a, core_in_b, drive_en;
   logic tb_en = 1'b0;
   logic [W-1:0] tb_val = '0;
   wire  [W-1:0] pad;
   int checks = 0;
   int failures = 0;

   assign pad = tb_en ? tb_val : {W{1'bz}};

   pio_slice #(.WIDTH(W)) i_pio_slice (
      .fast_clk(fast_clk), .sys_clk(sys_clk), .rst_n(rst_n),
      .cfg_demux(cfg_demux), .cfg_out_fn(cfg_out_fn), .cfg_out_reg(cfg_out_reg),
      .cfg_out_inv(cfg_out_inv), .cfg_oe_mode(cfg_oe_mode), .cfg_oe_reg(cfg_oe_reg),
      .cfg_od(cfg_od), .addr_strobe(addr_strobe), .core_out_a(core_out_a),
      .core_out_b(core_out_b), .out_sel(out_sel), .core_ts(core_ts),
      .core_in_a(core_in_a), .core_in_b(core_in_b), .drive_en(drive_en), .pad(pad)
   );

   // fast_clk rises at 2/10 of the period, sys_clk at 5/10.
   always begin
      #(CLK_PERIOD/5)     fast_clk = 1'b1;
      #(CLK_PERIOD*3/10)  sys_clk  = 1'b1;
      #(CLK_PERIOD/5)     fast_clk = 1'b0;
      #(CLK_PERIOD*3/10)  sys_clk  = 1'b0;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge sys_clk);
      #(CLK_PERIOD*3/10);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      tb_en = 1'b1; tb_val = 4'hF;
      cfg_demux = 1'b1; cfg_oe_mode = 2'd1; cfg_oe_reg = 1'b1; cfg_out_reg = 1'b1;
      rst_n = 1'b0;
      step();
      chk("R10 in_a", core_in_a, 0);
      chk("R10 in_b", core_in_b, 0);
      chk("R10 registered enable", drive_en, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_fast_capture();
      cfg_demux = 1'b0; cfg_oe_mode = 2'd3; tb_en = 1'b1; tb_val = 4'h0;
      do_reset();
      tb_val = 4'hA;
      #1;
      chk("R2 in_b follows pad", core_in_b, 4'hA);
      @(posedge fast_clk);
      #1 tb_val = 4'h5;
      step();
      chk("R1 in_a holds fast capture", core_in_a, 4'hA);
      chk("R2 in_b follows pad again", core_in_b, 4'h5);
   endtask

   task automatic t_demux();
      cfg_demux = 1'b1; cfg_oe_mode = 2'd3; tb_en = 1'b1; tb_val = 4'h0;
      do_reset();
      tb_val = 4'h3; addr_strobe = 1'b1;
      step();
      chk("R3 addr load", core_in_a, 4'h3);
      chk("R3 data held", core_in_b, 4'h0);
      tb_val = 4'hC; addr_strobe = 1'b0;
      step();
      chk("R3 data load", core_in_b, 4'hC);
      chk("R3 addr held", core_in_a, 4'h3);
      tb_val = 4'h7;
      step();
      chk("R3 data reload", core_in_b, 4'h7);
      tb_val = 4'h9; addr_strobe = 1'b1;
      step();
      chk("R3 addr reload", core_in_a, 4'h9);
      chk("R3 data kept", core_in_b, 4'h7);
      addr_strobe = 1'b0;
   endtask

   task automatic t_out_fn();
      logic [W-1:0] exp_v;
      tb_en = 1'b0; cfg_demux = 1'b0; cfg_oe_mode = 2'd0; cfg_od = 1'b0;
      cfg_out_reg = 1'b0; cfg_out_inv = 1'b0;
      do_reset();
      core_out_a = 4'b1100; core_out_b = 4'b1010;
      for (int f = 0; f < 5; f++) begin
         cfg_out_fn = (f == 4) ? 2'd0 : 2'(f);
         out_sel = (f == 4);
         case (f)
            0: exp_v = 4'b1100;
            1: exp_v = 4'b1000;
            2: exp_v = 4'b1110;
            3: exp_v = 4'b0110;
            default: exp_v = 4'b1010;
         endcase
         #1;
         chk("R4 function on pad", pad, exp_v);
         chk("R11 all driven", drive_en, 4'hF);
      end
      out_sel = 1'b0; cfg_out_fn = 2'd0;
   endtask

   task automatic t_out_reg();
      tb_en = 1'b0; cfg_oe_mode = 2'd0; cfg_od = 1'b0; cfg_out_fn = 2'd0;
      cfg_out_reg = 1'b1; cfg_out_inv = 1'b0; out_sel = 1'b0; core_out_a = '0;
      do_reset();
      core_out_a = 4'h5;
      #1;
      chk("R5 registered not yet", pad, 4'h0);
      step();
      chk("R5 registered after edge", pad, 4'h5);
      cfg_out_inv = 1'b1;
      #1;
      chk("R6 inverted", pad, 4'hA);
      cfg_out_reg = 1'b0; core_out_a = 4'h3;
      #1;
      chk("R5 R6 direct inverted", pad, 4'hC);
      cfg_out_inv = 1'b0;
   endtask

   task automatic t_oe();
      tb_en = 1'b0; cfg_od = 1'b0; cfg_out_reg = 1'b0; cfg_out_fn = 2'd0;
      core_out_a = 4'hF; cfg_oe_reg = 1'b0; cfg_oe_mode = 2'd1; core_ts = 1'b0;
      do_reset();
      core_ts = 1'b1; #1 chk("R7 high ts=1", drive_en, 4'hF);
      core_ts = 1'b0; #1 chk("R7 high ts=0", drive_en, 4'h0);
      cfg_oe_mode = 2'd2; #1 chk("R7 low ts=0", drive_en, 4'hF);
      core_ts = 1'b1; #1 chk("R7 low ts=1", drive_en, 4'h0);
      cfg_oe_mode = 2'd3; #1 chk("R7 off", drive_en, 4'h0);
      cfg_oe_mode = 2'd0; #1 chk("R7 on", drive_en, 4'hF);
      cfg_oe_mode = 2'd1; cfg_oe_reg = 1'b1; core_ts = 1'b0;
      do_reset();
      core_ts = 1'b1;
      #1 chk("R8 registered enable waits", drive_en, 4'h0);
      step();
      chk("R8 registered enable after edge", drive_en, 4'hF);
      cfg_oe_reg = 1'b0; core_ts = 1'b0;
   endtask

   task automatic t_od();
      tb_en = 1'b0; cfg_od = 1'b1; cfg_oe_mode = 2'd0; cfg_out_reg = 1'b0;
      cfg_out_fn = 2'd0; out_sel = 1'b0; cfg_demux = 1'b0; core_out_a = 4'b0101;
      do_reset();
      #1;
      chk("R9 only zeros driven", drive_en, 4'b1010);
      chk("R11 driven bits low", pad & 4'b1010, 4'b0000);
      core_out_a = 4'hF;
      #1;
      chk("R9 ones released", drive_en, 4'h0);
      tb_en = 1'b1; tb_val = 4'h6;
      #1;
      chk("R9 released pad readable", core_in_b, 4'h6);
      tb_en = 1'b0; core_out_a = 4'h0; cfg_oe_mode = 2'd3;
      #1;
      chk("R9 off overrides", drive_en, 4'h0);
      cfg_oe_mode = 2'd1; core_ts = 1'b1;
      #1;
      chk("R9 enabled zeros driven", drive_en, 4'hF);
      chk("R11 pad low", pad, 4'h0);
      core_ts = 1'b0; cfg_od = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_fast_capture();
      t_demux();
      t_out_fn();
      t_out_reg();
      t_oe();
      t_od();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule